// File: doc/BRIEF.md
# SMBus Byte-Data Master

This block is a small two-wire bus controller that runs exactly one kind of job: an SMBus write-byte-data or read-byte-data transaction to a 7-bit target. Software fills in the target address, a command (register offset) byte and, for writes, a data byte. It then sets one bit in a control register. The block shifts the whole transaction out on open-drain SCL/SDA lines and returns to idle. After a read, the received byte is left in a read-data register.

Completion, a NACK from the target and an interrupt forwarded from an attached client device are collected in a four-bit status register. Software clears status bits by writing ones to them. A mask register sits beside the status register, and a single level interrupt output reflects every unmasked status bit. The bus clock comes from a parameterised divider. Each bit on the wire takes four divider ticks.

Top module: `smb_byte_master`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0x01 (client source masked, transfer sources enabled), busy reads 0, irq_o is low and both SCL and SDA are released (drive enables low).
- R2: Register offsets are 0 control, 1 target address (bits 6:0), 2 command, 3 write data, 4 read data, 5 status, 6 mask. Writing control with bit 0 set starts a write transfer; with only bit 1 set it starts a read. Reading control returns busy in bit 0, and busy reads 1 from the cycle after the start until the status bits for that transfer are set.
- R3: A write sends START, address with R/W=0, command byte, data byte, STOP, each byte MSB first. Each byte is followed by an acknowledge slot. SCL rises once per bit and its period is 4*DIV clock cycles.
- R4: A read sends START, address with R/W=0, command byte, repeated START, address with R/W=1. It then clocks in one data byte, answers it with a master NACK, sends STOP, and stores the byte in the read-data register.
- R5: Status bit 0 is the client event, bit 1 write complete, bit 2 read complete, bit 3 NACK. Writing a status value clears exactly the bits written as one. Bits written as zero are kept.
- R6: An event that arrives in the same cycle as a clearing write to its bit leaves the bit set.
- R7: A NACK in any acknowledge slot the target owns ends the transfer with STOP. It sets the NACK bit together with the completion bit of that transfer, and no further bytes are sent.
- R8: A mask bit of 1 blocks its status bit from irq_o. Masked bits still latch. irq_o is high while any unmasked status bit is set.
- R9: The read-data register changes only when a read completes without NACK. Write transfers and NACKed reads leave it unchanged.
- R10: Control writes while busy are ignored and do not start, restart or alter the running transfer.
- R11: A rising edge of client_irq_i, seen through a two-flop synchroniser, sets status bit 0. A pin held high does not set the bit again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on reg_addr_i) |
| client_irq_i | input | 1 | Interrupt pin of the attached client device |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Drive SCL low when 1 |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check the following:
- a start from idle always raises busy;
- the done pulse lasts one cycle and finds both lines released;
- a transfer cannot drop busy early;
- a transfer event always sets its status bit, even against a clearing write;
- a clearing write with no competing event empties the bits it names;
- the read-data register holds unless a clean read finishes.

The byte order on the wire, the repeated START, the count of SCL edges, the SCL period, NACK on the address and on the command byte, masking, and the synchroniser timing behind R6 and R11 can only be shown by the bench scenarios, which use a target model that acknowledges by address.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned NSRC = 4;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_TADDR = 3'd1;
  localparam logic [2:0] OFS_CMD   = 3'd2;
  localparam logic [2:0] OFS_WDATA = 3'd3;
  localparam logic [2:0] OFS_RDATA = 3'd4;
  localparam logic [2:0] OFS_STAT  = 3'd5;
  localparam logic [2:0] OFS_MASK  = 3'd6;

  localparam int unsigned EV_CLIENT = 0;
  localparam int unsigned EV_WR     = 1;
  localparam int unsigned EV_RD     = 2;
  localparam int unsigned EV_NACK   = 3;

  localparam logic [NSRC-1:0] MASK_RST = 4'b0001;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_RSTART, S_STOP
  } seq_st_e;
endpackage

// File: rtl/smb_tick_div.sv
module smb_tick_div #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_wr_i,
  input  logic       start_rd_i,
  input  logic [6:0] addr_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       sda_i,
  output logic       run_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       is_rd_o,
  output logic [7:0] rx_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  seq_st_e    st_q;
  logic [1:0] ph_q;
  logic [3:0] bi_q;
  logic [1:0] seg_q;
  logic [7:0] sh_q, rx_q, cmd_q, wd_q;
  logic [6:0] ad_q;
  logic       rd_q, nack_q, done_q, smp_q, scl_q, sda_q;
  logic [1:0] sda_sync_q;
  logic       rx_phase;

  assign rx_phase = rd_q && (seg_q == 2'd3);

  // SDA input synchroniser; DIV must exceed its latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_sync_q <= 2'b11;
    else         sda_sync_q <= {sda_sync_q[0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ph_q   <= '0;
      bi_q   <= '0;
      seg_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cmd_q  <= '0;
      wd_q   <= '0;
      ad_q   <= '0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
      smp_q  <= 1'b1;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        ph_q <= '0;
        if ((start_wr_i || start_rd_i) && !done_q) begin
          st_q   <= S_START;
          rd_q   <= !start_wr_i;
          ad_q   <= addr_i;
          cmd_q  <= cmd_i;
          wd_q   <= wdata_i;
          seg_q  <= '0;
          nack_q <= 1'b0;
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 2'd1;
        case (st_q)
          S_START: begin
            case (ph_q)
              2'd0: begin scl_q <= 1'b0; sda_q <= 1'b0; end
              2'd1: sda_q <= 1'b1;
              2'd3: begin
                scl_q <= 1'b1;
                st_q  <= S_BIT;
                bi_q  <= '0;
                sh_q  <= {ad_q, 1'b0};
              end
              default: ;
            endcase
          end
          S_RSTART: begin
            case (ph_q)
              2'd0: begin scl_q <= 1'b1; sda_q <= 1'b0; end
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin
                scl_q <= 1'b1;
                st_q  <= S_BIT;
                bi_q  <= '0;
                sh_q  <= {ad_q, 1'b1};
              end
            endcase
          end
          S_BIT: begin
            case (ph_q)
              2'd0: begin
                scl_q <= 1'b1;
                sda_q <= (bi_q != 4'd8) && !rx_phase && !sh_q[7];
              end
              2'd1: scl_q <= 1'b0;
              2'd2: smp_q <= sda_sync_q[1];
              default: begin
                scl_q <= 1'b1;
                if (bi_q != 4'd8) begin
                  sh_q <= {sh_q[6:0], smp_q};
                  bi_q <= bi_q + 4'd1;
                end else if (rx_phase) begin
                  rx_q <= sh_q;
                  st_q <= S_STOP;
                end else if (smp_q) begin
                  nack_q <= 1'b1;
                  st_q   <= S_STOP;
                end else if (seg_q == 2'd1 && rd_q) begin
                  seg_q <= 2'd2;
                  st_q  <= S_RSTART;
                end else if (seg_q == 2'd2 && !rd_q) begin
                  st_q <= S_STOP;
                end else begin
                  seg_q <= seg_q + 2'd1;
                  bi_q  <= '0;
                  sh_q  <= (seg_q == 2'd0) ? cmd_q : (rd_q ? 8'h00 : wd_q);
                end
              end
            endcase
          end
          S_STOP: begin
            case (ph_q)
              2'd0: begin scl_q <= 1'b1; sda_q <= 1'b1; end
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: begin
                st_q   <= S_IDLE;
                done_q <= 1'b1;
              end
            endcase
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign run_o    = (st_q != S_IDLE);
  assign busy_o   = run_o || done_q;
  assign done_o   = done_q;
  assign nack_o   = nack_q;
  assign is_rd_o  = rd_q;
  assign rx_o     = rx_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i || start_rd_i) && !busy_o |=> busy_o);
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_lines_free_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scl_oe_o && !sda_oe_o);
  a_r10_no_early_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

// File: rtl/smb_irq.sv
module smb_irq
  import smb_pkg::*;
#(
  parameter int unsigned    N       = NSRC,
  parameter logic [N-1:0]   MASK_RV = MASK_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         client_i,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [2:0]   cs_q;
  logic         rise;
  logic [N-1:0] set_v, st_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '0;
    else         cs_q <= {cs_q[1:0], client_i};
  end

  assign rise  = cs_q[1] && !cs_q[2];
  assign set_v = ev_i | {{(N-1){1'b0}}, rise};

  for (genvar g = 0; g < N; g++) begin : g_stat
    // set beats clear so a fresh event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q[g] <= 1'b0;
      else if (set_v[g]) st_q[g] <= 1'b1;
      else if (clr_i[g]) st_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= MASK_RV;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
  assign irq_o  = |(st_q & ~mask_q);

  a_r6_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[EV_WR] |=> st_q[EV_WR]);
  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) && (set_v == '0) |=> ((st_q & $past(clr_i)) == '0));
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master
  import smb_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       client_irq_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       irq_o
);
  logic [6:0]      taddr_q;
  logic [7:0]      cmd_q, wd_q, rdata_q, seq_rx;
  logic            tick, run, busy, done, nack, is_rd;
  logic            ctrl_we, start_wr, start_rd;
  logic [NSRC-1:0] ev, clr, st, mask;

  assign ctrl_we  = reg_we_i && (reg_addr_i == OFS_CTRL) && !busy;
  assign start_wr = ctrl_we && reg_wdata_i[0];
  assign start_rd = ctrl_we && !reg_wdata_i[0] && reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taddr_q <= '0;
      cmd_q   <= '0;
      wd_q    <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFS_TADDR) taddr_q <= reg_wdata_i[6:0];
      if (reg_addr_i == OFS_CMD)   cmd_q   <= reg_wdata_i;
      if (reg_addr_i == OFS_WDATA) wd_q    <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (done && is_rd && !nack)  rdata_q <= seq_rx;
  end

  smb_tick_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .tick_o(tick)
  );

  smb_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .start_wr_i(start_wr),
    .start_rd_i(start_rd),
    .addr_i    (taddr_q),
    .cmd_i     (cmd_q),
    .wdata_i   (wd_q),
    .sda_i     (sda_i),
    .run_o     (run),
    .busy_o    (busy),
    .done_o    (done),
    .nack_o    (nack),
    .is_rd_o   (is_rd),
    .rx_o      (seq_rx),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o)
  );

  always_comb begin
    ev            = '0;
    ev[EV_WR]     = done && !is_rd;
    ev[EV_RD]     = done && is_rd;
    ev[EV_NACK]   = done && nack;
  end

  assign clr = (reg_we_i && reg_addr_i == OFS_STAT) ? reg_wdata_i[NSRC-1:0] : '0;

  smb_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .client_i (client_irq_i),
    .ev_i     (ev),
    .clr_i    (clr),
    .mask_we_i(reg_we_i && reg_addr_i == OFS_MASK),
    .mask_d_i (reg_wdata_i[NSRC-1:0]),
    .st_o     (st),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      OFS_CTRL:  reg_rdata_o = {7'b0, busy};
      OFS_TADDR: reg_rdata_o = {1'b0, taddr_q};
      OFS_CMD:   reg_rdata_o = cmd_q;
      OFS_WDATA: reg_rdata_o = wd_q;
      OFS_RDATA: reg_rdata_o = rdata_q;
      OFS_STAT:  reg_rdata_o = {{(8-NSRC){1'b0}}, st};
      OFS_MASK:  reg_rdata_o = {{(8-NSRC){1'b0}}, mask};
      default:   reg_rdata_o = 8'h00;
    endcase
  end

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && is_rd && !nack) |=> $stable(rdata_q));
endmodule

// File: tb/smb_byte_master_tb_top.sv
`timescale 1ns/1ps
module smb_byte_master_tb_top;
  import smb_pkg::*;

  localparam int unsigned DIV = 8;
  localparam logic [6:0] TGT = 7'h3A;
  localparam int NV = 8;
  // {rd, addr[6:0], cmd[7:0], data[7:0], expect_nack}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 7'h3A, 8'h10, 8'hA5, 1'b0},
    {1'b1, 7'h3A, 8'h10, 8'hA5, 1'b0},
    {1'b0, 7'h3A, 8'h22, 8'h5C, 1'b0},
    {1'b1, 7'h3A, 8'h22, 8'h5C, 1'b0},
    {1'b0, 7'h11, 8'h22, 8'hEE, 1'b1},
    {1'b1, 7'h11, 8'h22, 8'h00, 1'b1},
    {1'b0, 7'h3A, 8'hFF, 8'h00, 1'b0},
    {1'b1, 7'h3A, 8'hFF, 8'h00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       client_irq, scl_oe, sda_oe, irq;
  logic       scl, sda, t_low;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign scl = !scl_oe;
  assign sda = !(sda_oe || t_low);

  smb_byte_master #(.DIV(DIV)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr),
    .reg_we_i    (reg_we),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .client_irq_i(client_irq),
    .sda_i       (sda),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe),
    .irq_o       (irq)
  );

  // ---------------- target model ----------------
  logic [7:0] tmem [256];
  logic [7:0] shift, ptr, tx_sh;
  logic       active, in_ack, ack_pend, ack_val, go_tx, tx_mode, nack_cmd;
  int         rbit, tbit, byte_idx, scl_cnt, starts;
  realtime    t_first, t_second;

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    t_low = 1'b0; active = 1'b0; in_ack = 1'b0; ack_pend = 1'b0; ack_val = 1'b0;
    go_tx = 1'b0; tx_mode = 1'b0; nack_cmd = 1'b0; ptr = 8'h00;
    shift = 8'h00; tx_sh = 8'h00; rbit = 0; tbit = 0; byte_idx = 0;
    scl_cnt = 0; starts = 0; t_first = 0; t_second = 0;
  end

  always @(negedge sda) if (scl === 1'b1) begin
    active = 1'b1; byte_idx = 0; rbit = 0; tx_mode = 1'b0; in_ack = 1'b0;
    ack_pend = 1'b0; go_tx = 1'b0; t_low = 1'b0; starts++;
  end

  always @(posedge sda) if (scl === 1'b1) begin
    active = 1'b0; t_low = 1'b0;
  end

  always @(posedge scl) begin
    if (scl_cnt == 0) t_first = $realtime;
    if (scl_cnt == 1) t_second = $realtime;
    scl_cnt++;
    if (!active || in_ack || ack_pend) begin
    end else if (tx_mode) begin
      if (tbit < 8) tbit++;
      else begin tx_mode = 1'b0; active = 1'b0; end
    end else begin
      shift = {shift[6:0], sda};
      rbit++;
      if (rbit == 8) begin
        rbit = 0;
        if (byte_idx == 0) begin
          ack_val = (shift[7:1] == TGT);
          go_tx   = ack_val && shift[0];
        end else if (byte_idx == 1) begin
          ptr = shift;
          ack_val = !nack_cmd;
        end else begin
          tmem[ptr] = shift;
          ack_val = 1'b1;
        end
        byte_idx++;
        ack_pend = 1'b1;
      end
    end
  end

  always @(negedge scl) begin
    if (!active) begin
    end else if (ack_pend) begin
      ack_pend = 1'b0; in_ack = 1'b1; t_low = ack_val;
    end else if (in_ack) begin
      in_ack = 1'b0; t_low = 1'b0;
      if (!ack_val) active = 1'b0;
      else if (go_tx) begin
        go_tx = 1'b0; tx_mode = 1'b1; tbit = 0; tx_sh = tmem[ptr];
        t_low = !tx_sh[7];
      end
    end else if (tx_mode) begin
      t_low = (tbit < 8) ? !tx_sh[7-tbit] : 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    int n;
    n = 0;
    do begin rd_reg(OFS_CTRL, v); n++; end while (v[0] && n < 4000);
    if (v[0]) chk("R2 busy timeout", 32'(v[0]), 32'd0);
  endtask

  task automatic run_xfer(input logic rd, input logic [6:0] a, input logic [7:0] c,
                          input logic [7:0] d);
    wr_reg(OFS_TADDR, {1'b0, a});
    wr_reg(OFS_CMD, c);
    if (!rd) wr_reg(OFS_WDATA, d);
    scl_cnt = 0; starts = 0;
    wr_reg(OFS_CTRL, rd ? 8'h02 : 8'h01);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] v, exp_rd;
    rst_ni = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; client_irq = 1'b0;
    exp_rd = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_reg(OFS_STAT, v); chk("R1 status", v, 8'h00);
    rd_reg(OFS_MASK, v); chk("R1 mask", v, 8'h01);
    rd_reg(OFS_CTRL, v); chk("R1 busy", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

    for (int k = 0; k < NV; k++) begin
      logic vrd, vnk;
      logic [6:0] va;
      logic [7:0] vc, vd, st;
      {vrd, va, vc, vd, vnk} = VEC[k];
      run_xfer(vrd, va, vc, vd);
      rd_reg(OFS_STAT, st);
      chk("R5 status after xfer", st, {4'b0, vnk, vrd, !vrd, 1'b0});
      chk("R8 irq on event", irq, 1'b1);
      if (vnk) chk("R7 nack stops after address", scl_cnt, 10);
      else if (!vrd) begin
        chk("R3 byte written", tmem[vc], vd);
        chk("R3 scl edges", scl_cnt, 28);
        chk("R3 single start", starts, 1);
      end else begin
        exp_rd = vd;
        chk("R4 scl edges", scl_cnt, 38);
        chk("R4 repeated start", starts, 2);
      end
      if (k == 0) chk("R3 scl period ns", 32'(int'(t_second - t_first)), 4 * DIV * 8);
      if (vrd) begin
        rd_reg(OFS_RDATA, v);
        chk("R9 R4 read data", v, exp_rd);
      end
      wr_reg(OFS_STAT, st);
      rd_reg(OFS_STAT, v); chk("R5 cleared", v, 8'h00);
      chk("R8 irq cleared", irq, 1'b0);
    end

    // R10 control write while busy is ignored
    wr_reg(OFS_TADDR, {1'b0, TGT});
    wr_reg(OFS_CMD, 8'h40);
    wr_reg(OFS_WDATA, 8'h77);
    scl_cnt = 0; starts = 0;
    wr_reg(OFS_CTRL, 8'h01);
    rd_reg(OFS_CTRL, v); chk("R2 busy during xfer", v[0], 1'b1);
    wr_reg(OFS_CTRL, 8'h02);
    wait_idle();
    rd_reg(OFS_STAT, v); chk("R10 only write done", v, 8'h02);
    chk("R10 no restart", scl_cnt, 28);
    chk("R10 data intact", tmem[8'h40], 8'h77);
    rd_reg(OFS_RDATA, v); chk("R9 unchanged by write", v, exp_rd);
    wr_reg(OFS_STAT, 8'h02);

    // R7 NACK on command byte
    nack_cmd = 1'b1;
    run_xfer(1'b0, TGT, 8'h41, 8'h99);
    rd_reg(OFS_STAT, v); chk("R7 nack on cmd status", v, 8'h0A);
    chk("R7 nack on cmd stops", scl_cnt, 19);
    chk("R7 no data byte", tmem[8'h41], 8'h00);
    nack_cmd = 1'b0;
    wr_reg(OFS_STAT, 8'h0A);

    // R8 masked bits latch but raise no irq
    wr_reg(OFS_MASK, 8'h03);
    rd_reg(OFS_MASK, v); chk("R8 mask readback", v, 8'h03);
    run_xfer(1'b0, TGT, 8'h42, 8'h12);
    rd_reg(OFS_STAT, v); chk("R8 masked bit latched", v, 8'h02);
    chk("R8 masked irq low", irq, 1'b0);
    wr_reg(OFS_MASK, 8'h00);
    #1 chk("R8 unmask raises irq", irq, 1'b1);
    wr_reg(OFS_STAT, 8'h02);

    // R11 client pin edge
    @(negedge clk) client_irq = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(OFS_STAT, v); chk("R11 client edge", v, 8'h01);
    chk("R11 client irq", irq, 1'b1);
    wr_reg(OFS_STAT, 8'h01);
    repeat (4) @(negedge clk);
    rd_reg(OFS_STAT, v); chk("R11 level no reset", v, 8'h00);
    @(negedge clk) client_irq = 1'b0;
    repeat (4) @(negedge clk);
    client_irq = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(OFS_STAT, v); chk("R11 second edge", v, 8'h01);

    // R6 event and clear in the same cycle (set on third edge after pin rise)
    @(negedge clk) client_irq = 1'b0;
    repeat (4) @(negedge clk);
    client_irq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = OFS_STAT; reg_wdata = 8'h01; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd_reg(OFS_STAT, v); chk("R6 set wins over clear", v, 8'h01);

    // R5 partial clear
    run_xfer(1'b0, TGT, 8'h43, 8'h34);
    rd_reg(OFS_STAT, v); chk("R5 two bits set", v, 8'h03);
    wr_reg(OFS_STAT, 8'h02);
    rd_reg(OFS_STAT, v); chk("R5 partial clear", v, 8'h01);

    finish_run();
  end
endmodule